// File: doc/BRIEF.md
# Bidirectional GPIO Port with Alternate-Function Override

This block is one 8-bit general-purpose I/O port on a simple synchronous register bus. Software sets each pin's direction on its own, writes an output latch, and reads either the latch it wrote or the levels now on the pins. The pads are modelled as three separate vectors: incoming level, outgoing value and per-bit output enable. The chip's pad ring combines them.

Two alternate functions can take the whole port. The first is an external multiplexed address/data bus, which carries its low byte here. The second is a parallel slave port. A control register picks the owner, and the external bus wins when both are requested. While either alternate function owns the pins, software can still write the direction and latch registers and read them back. Those values reach the pads only once ownership returns to the port.

Incoming pad levels pass through a two-flop synchroniser before the pin-read path sees them. Reset is asynchronous and active low. Its release is expected to be synchronised upstream.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is asserted and right after it, all output enables are low. The direction register reads 0xFF, the latch reads 0x00, and the control register reads 0x01 (external bus disabled, slave mode off).
- R2: In normal port mode, a direction bit of 1 disables that pin's driver. A direction bit of 0 enables the driver, and the pin carries the latch bit.
- R3: A read at address 1 (latch) returns the stored latch value, whatever the pins carry.
- R4: A read at address 0 (pins) returns the pad levels through a two-stage synchroniser. A change on the pads shows up on read data after the second rising clock edge, and not after the first.
- R5: A write to address 0 (pins) stores the write data in the output latch.
- R6: A write to any register takes effect at the next rising edge, and not before. Address 2 is direction and reads back as written.
- R7: Address 3 is the control register. Bit 0 = 1 disables the external bus. While bit 0 = 0, the pads carry the bus data, all enables follow the bus's single drive-enable input, and the bus-owner flag is high.
- R8: While bit 0 = 1 and bit 1 = 1, the slave-port function owns the pads: its data and its single drive enable reach the pins, and the slave-owner flag is high.
- R9: When bit 0 = 0 and bit 1 = 1, the external bus has priority over the slave port.
- R10: Direction and latch writes made during an override are stored and read back, but do not reach the pads until the override is released. After release, they apply at once.
- R11: A direction value of 0xCF drives only bits 5:4; all other bits are inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register select: 0 pins, 1 latch, 2 direction, 3 control |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data for the selected register |
| pad_in_i | input | 8 | Levels present on the pads |
| pad_out_o | output | 8 | Value driven to the pads |
| pad_oe_o | output | 8 | Per-bit output enable, 1 = drive |
| ebus_dout_i | input | 8 | Low byte from the external memory bus |
| ebus_oe_i | input | 1 | External bus drive enable |
| slv_dout_i | input | 8 | Data from the slave-port function |
| slv_oe_i | input | 1 | Slave-port drive enable |
| ebus_sel_o | output | 1 | External bus owns the pads |
| slv_sel_o | output | 1 | Slave port owns the pads |

## Verification
A wrong direction or latch bit shows on pad_oe_o or pad_out_o in the cycle after the write that set it, as long as the port owns its pins. A fault hidden by an override shows the moment the override is released. A wrong owner choice sends the wrong source to the pads in the cycle the control write lands. A broken synchroniser shows as pin reads that arrive one edge early or late, or never.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_PIN = 2'd0,
    SEL_LAT = 2'd1,
    SEL_DIR = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OWN_PORT  = 2'd0,
    OWN_SLAVE = 2'd1,
    OWN_EBUS  = 2'd2
  } owner_e;

  localparam int unsigned CTL_BUSOFF_BIT = 0;
  localparam int unsigned CTL_SLAVE_BIT  = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = d_i;
      end else begin : g_next
        assign stg_d[s] = stg_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_q_o,
  output logic [W-1:0] lat_q_o,
  output logic         busoff_q_o,
  output logic         slave_q_o
);
  reg_sel_e     sel;
  logic         dir_en, lat_en, ctl_en;
  logic [W-1:0] dir_q, dir_d, lat_q, lat_d;
  logic         busoff_q, busoff_d, slave_q, slave_d;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    dir_en   = we_i && (sel == SEL_DIR);
    lat_en   = we_i && ((sel == SEL_LAT) || (sel == SEL_PIN));
    ctl_en   = we_i && (sel == SEL_CTL);
    dir_d    = wdata_i;
    lat_d    = wdata_i;
    busoff_d = wdata_i[CTL_BUSOFF_BIT];
    slave_d  = wdata_i[CTL_SLAVE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '1;
      lat_q    <= '0;
      busoff_q <= 1'b1;
      slave_q  <= 1'b0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (lat_en) lat_q <= lat_d;
      if (ctl_en) begin
        busoff_q <= busoff_d;
        slave_q  <= slave_d;
      end
    end
  end

  assign dir_q_o    = dir_q;
  assign lat_q_o    = lat_q;
  assign busoff_q_o = busoff_q;
  assign slave_q_o  = slave_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         busoff_i,
  input  logic         slave_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] ebus_dout_i,
  input  logic         ebus_oe_i,
  input  logic [W-1:0] slv_dout_i,
  input  logic         slv_oe_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output owner_e       owner_o
);
  owner_e owner;

  always_comb begin
    if (!busoff_i)    owner = OWN_EBUS;
    else if (slave_i) owner = OWN_SLAVE;
    else              owner = OWN_PORT;
  end

  always_comb begin
    unique case (owner)
      OWN_EBUS: begin
        pad_out_o = ebus_dout_i;
        pad_oe_o  = {W{ebus_oe_i}};
      end
      OWN_SLAVE: begin
        pad_out_o = slv_dout_i;
        pad_oe_o  = {W{slv_oe_i}};
      end
      default: begin
        pad_out_o = lat_i;
        pad_oe_o  = ~dir_i;
      end
    endcase
  end

  assign owner_o = owner;
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   reg_addr_i,
  input  logic         reg_we_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  input  logic [W-1:0] ebus_dout_i,
  input  logic         ebus_oe_i,
  input  logic [W-1:0] slv_dout_i,
  input  logic         slv_oe_i,
  output logic         ebus_sel_o,
  output logic         slv_sel_o
);
  localparam int unsigned CTL_PAD = W - 2;

  logic [W-1:0] dir_q, lat_q, pin_sync;
  logic         busoff_q, slave_q;
  owner_e       owner;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .dir_q_o   (dir_q),
    .lat_q_o   (lat_q),
    .busoff_q_o(busoff_q),
    .slave_q_o (slave_q)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .busoff_i   (busoff_q),
    .slave_i    (slave_q),
    .dir_i      (dir_q),
    .lat_i      (lat_q),
    .ebus_dout_i(ebus_dout_i),
    .ebus_oe_i  (ebus_oe_i),
    .slv_dout_i (slv_dout_i),
    .slv_oe_i   (slv_oe_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .owner_o    (owner)
  );

  always_comb begin
    unique case (reg_sel_e'(reg_addr_i))
      SEL_PIN: reg_rdata_o = pin_sync;
      SEL_LAT: reg_rdata_o = lat_q;
      SEL_DIR: reg_rdata_o = dir_q;
      default: reg_rdata_o = {{CTL_PAD{1'b0}}, slave_q, busoff_q};
    endcase
  end

  assign ebus_sel_o = (owner == OWN_EBUS);
  assign slv_sel_o  = (owner == OWN_SLAVE);
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   reg_addr_i,
  input logic         reg_we_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] reg_rdata_o,
  input logic [W-1:0] pad_in_i,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] ebus_dout_i,
  input logic         ebus_oe_i,
  input logic [W-1:0] slv_dout_i,
  input logic         slv_oe_i,
  input logic         busoff_q,
  input logic         slave_q,
  input logic [W-1:0] lat_q
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R2 and R6: a direction write in port mode shows on the enables one edge later
  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd2 && busoff_q && !slave_q)
      |=> (pad_oe_o == ~$past(reg_wdata_i)));

  // R5: a write at the pin address lands in the output latch
  assert_pin_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0) |=> (lat_q == $past(reg_wdata_i)));

  // R7: the external bus drives all enables while it owns the port
  assert_ebus_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busoff_q |-> (pad_oe_o == {W{ebus_oe_i}}));

  // R9: the bus wins over a pending slave-mode request
  assert_ebus_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busoff_q && slave_q) |-> (pad_out_o == ebus_dout_i));

  // R8: the slave port drives the pads when it alone is selected
  assert_slave_own_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busoff_q && slave_q) |-> (pad_out_o == slv_dout_i && pad_oe_o == {W{slv_oe_i}}));

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      // R4: pin reads lag the pads by exactly two edges
      assert_pin_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2 && reg_addr_i == 2'd0) |-> (reg_rdata_o == $past(pad_in_i, 2)));
    end
  endgenerate
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .pad_in_i   (pad_in_i),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o),
  .ebus_dout_i(ebus_dout_i),
  .ebus_oe_i  (ebus_oe_i),
  .slv_dout_i (slv_dout_i),
  .slv_oe_i   (slv_oe_i),
  .busoff_q   (busoff_q),
  .slave_q    (slave_q),
  .lat_q      (lat_q)
);

// File: tb/gpio_port_ovr_tb.sv
module gpio_port_ovr_tb;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [1:0]   reg_addr_i;
  logic         reg_we_i;
  logic [W-1:0] reg_wdata_i, reg_rdata_o;
  logic [W-1:0] pad_in_i, pad_out_o, pad_oe_o;
  logic [W-1:0] ebus_dout_i, slv_dout_i;
  logic         ebus_oe_i, slv_oe_i, ebus_sel_o, slv_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_port_ovr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .ebus_dout_i(ebus_dout_i), .ebus_oe_i(ebus_oe_i),
    .slv_dout_i(slv_dout_i), .slv_oe_i(slv_oe_i),
    .ebus_sel_o(ebus_sel_o), .slv_sel_o(slv_sel_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    check("R1 oe", pad_oe_o, 8'h00);
    rd(2'd2, v); check("R1 dir", v, 8'hFF);
    rd(2'd1, v); check("R1 lat", v, 8'h00);
    rd(2'd3, v); check("R1 ctl", v, 8'h01);
  endtask

  task automatic t_dir_drive();
    logic [W-1:0] v;
    wr(2'd1, 8'h5A);
    @(negedge clk_i);
    reg_addr_i = 2'd2; reg_wdata_i = 8'h00; reg_we_i = 1'b1;
    #1 check("R6 before edge", pad_oe_o, 8'h00);
    @(negedge clk_i); reg_we_i = 1'b0;
    check("R2 oe all", pad_oe_o, 8'hFF);
    check("R2 out", pad_out_o, 8'h5A);
    wr(2'd2, 8'hF0);
    check("R2 oe low nibble", pad_oe_o, 8'h0F);
    check("R2 out low nibble", pad_out_o & pad_oe_o, 8'h0A);
    rd(2'd2, v); check("R6 dir readback", v, 8'hF0);
  endtask

  task automatic t_example();
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hCF);
    check("R11 oe", pad_oe_o, 8'h30);
    check("R11 out", pad_out_o & pad_oe_o, 8'h30);
  endtask

  task automatic t_latch_vs_pin();
    logic [W-1:0] v;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hA5);
    pad_in_i = 8'h3C;
    repeat (3) @(negedge clk_i);
    rd(2'd1, v); check("R3 lat", v, 8'hA5);
    rd(2'd0, v); check("R3 pin", v, 8'h3C);
  endtask

  task automatic t_pin_write();
    logic [W-1:0] v;
    wr(2'd0, 8'h96);
    rd(2'd1, v); check("R5 lat", v, 8'h96);
    check("R5 pad", pad_out_o, 8'h96);
  endtask

  task automatic t_sync();
    logic [W-1:0] v;
    pad_in_i = 8'h11;
    repeat (3) @(negedge clk_i);
    pad_in_i = 8'hEE;
    @(negedge clk_i);
    rd(2'd0, v); check("R4 one edge", v, 8'h11);
    @(negedge clk_i);
    rd(2'd0, v); check("R4 two edges", v, 8'hEE);
  endtask

  task automatic t_ext();
    ebus_dout_i = 8'hC3; ebus_oe_i = 1'b1;
    wr(2'd3, 8'h00);
    check("R7 out", pad_out_o, 8'hC3);
    check("R7 oe", pad_oe_o, 8'hFF);
    check("R7 sel", {7'd0, ebus_sel_o}, 8'h01);
    ebus_oe_i = 1'b0; #1;
    check("R7 oe off", pad_oe_o, 8'h00);
  endtask

  task automatic t_slave();
    slv_dout_i = 8'h69; slv_oe_i = 1'b1;
    wr(2'd3, 8'h03);
    check("R8 out", pad_out_o, 8'h69);
    check("R8 oe", pad_oe_o, 8'hFF);
    check("R8 sel", {6'd0, ebus_sel_o, slv_sel_o}, 8'h01);
  endtask

  task automatic t_prio();
    ebus_dout_i = 8'h1E; ebus_oe_i = 1'b1;
    wr(2'd3, 8'h02);
    check("R9 out", pad_out_o, 8'h1E);
    check("R9 sel", {6'd0, ebus_sel_o, slv_sel_o}, 8'h02);
  endtask

  task automatic t_hold();
    logic [W-1:0] v;
    wr(2'd3, 8'h00);
    ebus_dout_i = 8'h44; ebus_oe_i = 1'b0;
    wr(2'd2, 8'h0F);
    wr(2'd1, 8'h77);
    check("R10 pads held oe", pad_oe_o, 8'h00);
    check("R10 pads held out", pad_out_o, 8'h44);
    rd(2'd2, v); check("R10 dir stored", v, 8'h0F);
    rd(2'd1, v); check("R10 lat stored", v, 8'h77);
    wr(2'd3, 8'h01);
    check("R10 release oe", pad_oe_o, 8'hF0);
    check("R10 release out", pad_out_o & pad_oe_o, 8'h70);
  endtask

  initial begin
    rst_ni = 1'b1; reg_addr_i = '0; reg_we_i = 1'b0; reg_wdata_i = '0;
    pad_in_i = '0; ebus_dout_i = '0; ebus_oe_i = 1'b0;
    slv_dout_i = '0; slv_oe_i = 1'b0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_dir_drive();
    t_example();
    t_latch_vs_pin();
    t_pin_write();
    t_sync();
    t_ext();
    t_slave();
    t_prio();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule